// File: doc/BRIEF.md
# Delay-Slot Next-PC Unit

This block owns the fetch program counter of a 32-bit RISC fetch stage whose architecture has exactly one branch delay slot. Each cycle in which `valid_i` is high, the instruction at `fetch_pc_o` is taken as consumed. The block then picks the address to fetch next from a decoded control opcode, two compare operands, a 16-bit branch offset, a 26-bit jump index and a register jump source.

A taken redirect never lands at once. The word that follows a branch or jump always runs first, and the target is fetched after it. Branch-and-link and jump-and-link ops request a write to register 31 with a return address that skips the slot. A control op that sits in a delay slot runs as a plain instruction: it does not redirect and does not link. Operand reads, the ALU and the instruction memory live outside this block.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, `fetch_pc_o` equals the parameter RESET_VEC (default 32'hBFC0_0000) and `in_slot_o` is 0.
- R2: While `valid_i` is low, `fetch_pc_o` and `in_slot_o` hold their values.
- R3: A consumed op that is not a control op (op code 0, or any code from 12 to 15) outside a slot moves `fetch_pc_o` to the old value plus 4.
- R4: The branch target is `fetch_pc_o` + 4 + (`imm_i` sign-extended and shifted left by 2). Op 1 is taken when `cmp_a_i == cmp_b_i` and op 2 when they differ.
- R5: The zero compares treat `cmp_a_i` as signed. Op 3 is taken when it is <= 0, op 4 when > 0, op 5 when < 0 and op 6 when >= 0. Op 7 tests < 0 and op 8 tests >= 0; both link.
- R6: After a taken control op the next fetch is the old PC + 4 with `in_slot_o` = 1, and the fetch after the slot is the target.
- R7: After a not-taken branch the slot at PC + 4 is fetched, then PC + 8.
- R8: Op 9 (jump) and op 10 (jump and link) are always taken, with target {`fetch_pc_o`[31:28], `jidx_i`, 2'b00}.
- R9: Op 11 (register jump) is always taken, with target `jr_src_i`.
- R10: Ops 7, 8 and 10 outside a slot raise `link_we_o` with `link_addr_o` = `fetch_pc_o` + 8. For ops 7 and 8 this holds whether or not the branch is taken.
- R11: A control op consumed in a delay slot gives `taken_o` = 0 and `link_we_o` = 0, and fetch goes on as set by the op before it.
- R12: `taken_o` is 1 in a consumed cycle exactly when a control op outside a slot is taken, and `next_pc_o` shows the PC value to be loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | The instruction at fetch_pc_o is consumed this cycle |
| op_i | input | 4 | Decoded control op code |
| cmp_a_i | input | 32 | First compare operand |
| cmp_b_i | input | 32 | Second compare operand |
| imm_i | input | 16 | Branch word offset |
| jidx_i | input | 26 | Jump word index |
| jr_src_i | input | 32 | Register jump target |
| fetch_pc_o | output | 32 | Current fetch address |
| next_pc_o | output | 32 | Value the PC takes at the next edge |
| taken_o | output | 1 | Control op taken this cycle |
| in_slot_o | output | 1 | Current instruction sits in a delay slot |
| link_we_o | output | 1 | Request to write register 31 |
| link_addr_o | output | 32 | Return address to be written |

## Verification
The assertions check on every cycle that the PC holds when no instruction is consumed and that sequential and not-taken steps add 4. They also check that a taken op steps into a slot at PC + 4, and that an op inside a slot neither redirects nor links. Only the bench scenarios can show that the slot is followed by the right target for each compare sign and each boundary value. The same holds for the jump concatenation, register jumps, the link address of linking branches that are not taken, and a slot that is held across idle cycles.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [3:0] {
        OP_NONE    = 4'd0,
        OP_BR_EQ   = 4'd1,
        OP_BR_NE   = 4'd2,
        OP_BR_LEZ  = 4'd3,
        OP_BR_GTZ  = 4'd4,
        OP_BR_LTZ  = 4'd5,
        OP_BR_GEZ  = 4'd6,
        OP_BRL_LTZ = 4'd7,
        OP_BRL_GEZ = 4'd8,
        OP_JMP     = 4'd9,
        OP_JMP_LNK = 4'd10,
        OP_JMP_REG = 4'd11
    } ctl_op_e;

    typedef struct packed {
        logic [31:0] pc;
        logic        in_slot;
        logic        redirect;
        logic [31:0] tgt;
    } npc_state_t;

endpackage

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic              is_ctl_o,
    output logic              take_o,
    output logic              link_o
);
    logic a_neg;
    logic a_zero;

    always_comb begin
        a_neg    = a_i[DATA_W-1];
        a_zero   = (a_i == '0);
        is_ctl_o = 1'b1;
        take_o   = 1'b0;
        link_o   = 1'b0;
        case (op_i)
            OP_BR_EQ:   take_o = (a_i == b_i);
            OP_BR_NE:   take_o = (a_i != b_i);
            OP_BR_LEZ:  take_o = a_neg || a_zero;
            OP_BR_GTZ:  take_o = !a_neg && !a_zero;
            OP_BR_LTZ:  take_o = a_neg;
            OP_BR_GEZ:  take_o = !a_neg;
            OP_BRL_LTZ: begin take_o = a_neg;  link_o = 1'b1; end
            OP_BRL_GEZ: begin take_o = !a_neg; link_o = 1'b1; end
            OP_JMP:     take_o = 1'b1;
            OP_JMP_LNK: begin take_o = 1'b1; link_o = 1'b1; end
            OP_JMP_REG: take_o = 1'b1;
            default:    is_ctl_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int JIDX_W = 26
) (
    input  logic [3:0]        op_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [OFF_W-1:0]  imm_i,
    input  logic [JIDX_W-1:0] jidx_i,
    input  logic [ADDR_W-1:0] jr_i,
    output logic [ADDR_W-1:0] tgt_o
);
    localparam int EXT_W = ADDR_W - OFF_W - 2;
    localparam int HI_W  = ADDR_W - JIDX_W - 2;

    logic [ADDR_W-1:0] br_off;
    logic [ADDR_W-1:0] br_tgt;
    logic [ADDR_W-1:0] jmp_tgt;

    always_comb begin
        br_off  = {{EXT_W{imm_i[OFF_W-1]}}, imm_i, 2'b00};
        br_tgt  = pc_i + ADDR_W'(4) + br_off;
        jmp_tgt = {pc_i[ADDR_W-1 -: HI_W], jidx_i, 2'b00};
        case (op_i)
            OP_JMP, OP_JMP_LNK: tgt_o = jmp_tgt;
            OP_JMP_REG:         tgt_o = jr_i;
            default:            tgt_o = br_tgt;
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [31:0] RESET_VEC = 32'hBFC0_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        valid_i,
    input  logic [3:0]  op_i,
    input  logic [31:0] cmp_a_i,
    input  logic [31:0] cmp_b_i,
    input  logic [15:0] imm_i,
    input  logic [25:0] jidx_i,
    input  logic [31:0] jr_src_i,
    output logic [31:0] fetch_pc_o,
    output logic [31:0] next_pc_o,
    output logic        taken_o,
    output logic        in_slot_o,
    output logic        link_we_o,
    output logic [31:0] link_addr_o
);
    npc_state_t st_q, st_d;
    logic        is_ctl, take, link;
    logic [31:0] tgt;

    npc_cond #(.DATA_W(32)) u_cond (
        .op_i(op_i), .a_i(cmp_a_i), .b_i(cmp_b_i),
        .is_ctl_o(is_ctl), .take_o(take), .link_o(link)
    );

    npc_target #(.ADDR_W(32), .OFF_W(16), .JIDX_W(26)) u_tgt (
        .op_i(op_i), .pc_i(st_q.pc), .imm_i(imm_i), .jidx_i(jidx_i),
        .jr_i(jr_src_i), .tgt_o(tgt)
    );

    always_comb begin
        st_d        = st_q;
        taken_o     = 1'b0;
        link_we_o   = 1'b0;
        link_addr_o = st_q.pc + 32'd8;
        if (valid_i) begin
            if (st_q.in_slot) begin
                st_d.pc       = st_q.redirect ? st_q.tgt : st_q.pc + 32'd4;
                st_d.in_slot  = 1'b0;
                st_d.redirect = 1'b0;
            end else begin
                st_d.pc = st_q.pc + 32'd4;
                if (is_ctl) begin
                    st_d.in_slot  = 1'b1;
                    st_d.redirect = take;
                    st_d.tgt      = tgt;
                    taken_o       = take;
                    link_we_o     = link;
                end
            end
        end
        next_pc_o = st_d.pc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{pc: RESET_VEC, in_slot: 1'b0, redirect: 1'b0, tgt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_pc_o = st_q.pc;
    assign in_slot_o  = st_q.in_slot;

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(fetch_pc_o) && $stable(in_slot_o));

    a_r3_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && !in_slot_o && !taken_o |=> fetch_pc_o == $past(fetch_pc_o) + 32'd4);

    a_r6_enter_slot: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && !in_slot_o && taken_o |=> in_slot_o && fetch_pc_o == $past(fetch_pc_o) + 32'd4);

    a_r11_slot_inert: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && in_slot_o |-> !taken_o && !link_we_o);

endmodule

// File: tb/npc_unit_tb.sv
module npc_unit_tb;
    localparam logic [31:0] RV = 32'hBFC0_0000;

    typedef struct {
        logic [31:0] nxt;
        logic        taken;
        logic        lwe;
        logic [31:0] laddr;
        string       tag;
    } exp_t;

    logic        clk = 0, rst_n = 0, valid_i = 0;
    logic [3:0]  op_i = 0;
    logic [31:0] cmp_a_i = 0, cmp_b_i = 0, jr_src_i = 0;
    logic [15:0] imm_i = 0;
    logic [25:0] jidx_i = 0;
    logic [31:0] fetch_pc_o, next_pc_o, link_addr_o;
    logic        taken_o, in_slot_o, link_we_o;

    int checks = 0, errors = 0;
    exp_t q[$];
    bit   done = 0;

    logic [31:0] r_pc = RV, r_tgt = 0;
    logic        r_slot = 0, r_red = 0;

    always #5 clk = ~clk;

    npc_unit #(.RESET_VEC(RV)) u_dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .cmp_a_i(cmp_a_i), .cmp_b_i(cmp_b_i), .imm_i(imm_i), .jidx_i(jidx_i),
        .jr_src_i(jr_src_i), .fetch_pc_o(fetch_pc_o), .next_pc_o(next_pc_o),
        .taken_o(taken_o), .in_slot_o(in_slot_o), .link_we_o(link_we_o),
        .link_addr_o(link_addr_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] imm, input logic [25:0] ji, input logic [31:0] jr,
                         input string tag);
        exp_t e;
        bit ctl, tk, lk;
        logic [31:0] t;
        @(negedge clk);
        valid_i = 1; op_i = op; cmp_a_i = a; cmp_b_i = b; imm_i = imm; jidx_i = ji; jr_src_i = jr;
        ctl = (op >= 1 && op <= 11);
        case (op)
            1: tk = (a == b);
            2: tk = (a != b);
            3: tk = ($signed(a) <= 0);
            4: tk = ($signed(a) > 0);
            5, 7: tk = ($signed(a) < 0);
            6, 8: tk = ($signed(a) >= 0);
            default: tk = ctl;
        endcase
        lk = (op == 7 || op == 8 || op == 10);
        if (op == 9 || op == 10) t = {r_pc[31:28], ji, 2'b00};
        else if (op == 11) t = jr;
        else t = r_pc + 4 + {{14{imm[15]}}, imm, 2'b00};
        e.tag = tag; e.laddr = r_pc + 8;
        if (r_slot) begin
            e.nxt = r_red ? r_tgt : r_pc + 4;
            e.taken = 0; e.lwe = 0;
            r_slot = 0; r_red = 0;
        end else begin
            e.nxt = r_pc + 4;
            e.taken = ctl && tk; e.lwe = ctl && lk;
            if (ctl) begin r_slot = 1; r_red = tk; r_tgt = t; end
        end
        r_pc = e.nxt;
        q.push_back(e);
    endtask

    initial begin : monitor
        forever begin
            logic t, l;
            logic [31:0] la, np;
            exp_t e;
            @(negedge clk);
            #3;
            if (valid_i && rst_n) begin
                t = taken_o; l = link_we_o; la = link_addr_o; np = next_pc_o;
                @(posedge clk);
                #1;
                e = q.pop_front();
                chk(t === e.taken, {e.tag, " taken"}, {31'd0, t}, {31'd0, e.taken});
                chk(l === e.lwe, {e.tag, " link_we"}, {31'd0, l}, {31'd0, e.lwe});
                if (e.lwe) chk(la === e.laddr, {e.tag, " link_addr R10"}, la, e.laddr);
                chk(np === e.nxt, {e.tag, " next_pc R12"}, np, e.nxt);
                chk(fetch_pc_o === e.nxt, {e.tag, " fetch_pc"}, fetch_pc_o, e.nxt);
            end
        end
    end

    initial begin : watchdog
        #2000000;
        errors++; checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] held;
        repeat (3) @(negedge clk);
        chk(fetch_pc_o === RV, "R1 reset pc", fetch_pc_o, RV);
        chk(in_slot_o === 1'b0, "R1 reset slot", {31'd0, in_slot_o}, 32'd0);
        rst_n = 1;
        @(negedge clk);
        chk(fetch_pc_o === RV, "R1 pc after release", fetch_pc_o, RV);

        issue(0, 0, 0, 0, 0, 0, "R3 plain");
        issue(13, 0, 0, 0, 0, 0, "R3 unused code");
        issue(1, 5, 5, 16'd4, 0, 0, "R4 eq taken R6");
        issue(0, 0, 0, 0, 0, 0, "R6 slot to target");
        issue(2, 7, 7, 16'd9, 0, 0, "R7 ne not taken");
        issue(0, 0, 0, 0, 0, 0, "R7 slot");
        issue(0, 0, 0, 0, 0, 0, "R7 after slot");
        issue(2, 1, 2, 16'hFFFC, 0, 0, "R4 ne back");
        issue(9, 0, 0, 0, 26'h155, 0, "R11 jump in slot");
        issue(3, 0, 0, 16'd2, 0, 0, "R5 lez zero");
        issue(0, 0, 0, 0, 0, 0, "R5 slot");
        issue(4, 0, 0, 16'd2, 0, 0, "R5 gtz zero");
        issue(0, 0, 0, 0, 0, 0, "R5 slot");
        issue(5, 32'h8000_0000, 0, 16'd3, 0, 0, "R5 ltz min");
        issue(0, 0, 0, 0, 0, 0, "R5 slot");
        issue(6, 32'hFFFF_FFFF, 0, 16'd3, 0, 0, "R5 gez neg");
        issue(0, 0, 0, 0, 0, 0, "R5 slot");
        issue(6, 0, 0, 16'd1, 0, 0, "R5 gez zero");
        issue(0, 0, 0, 0, 0, 0, "R5 slot");
        issue(7, 32'd1, 0, 16'd5, 0, 0, "R10 link branch not taken");
        issue(0, 0, 0, 0, 0, 0, "R10 slot");
        issue(8, 32'd3, 0, 16'd6, 0, 0, "R10 link branch taken");
        issue(10, 0, 0, 0, 26'h3, 0, "R11 link jump in slot");
        issue(9, 0, 0, 0, 26'h2A_AAAA, 0, "R8 jump");
        // R2: idle while the slot is pending
        @(negedge clk);
        valid_i = 0;
        held = fetch_pc_o;
        repeat (3) @(negedge clk);
        chk(fetch_pc_o === held, "R2 hold pc", fetch_pc_o, held);
        chk(in_slot_o === 1'b1, "R2 hold slot", {31'd0, in_slot_o}, 32'd1);
        issue(0, 0, 0, 0, 0, 0, "R8 slot to jump target");
        issue(10, 0, 0, 0, 26'h10, 0, "R10 jump link R8");
        issue(0, 0, 0, 0, 0, 0, "R8 slot");
        issue(11, 0, 0, 0, 0, 32'h0000_1234, "R9 reg jump");
        issue(0, 0, 0, 0, 0, 0, "R9 slot");
        issue(0, 0, 0, 0, 0, 0, "R3 after reg jump");
        @(negedge clk);
        valid_i = 0;
        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R12 scoreboard drained", q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule